// File: doc/BRIEF.md
# Exception-Tagged Receive Queue Controller

This block sits between a character deserializer and a CPU. Each received character arrives with error flags. A clean character takes one slot in a byte queue. A character with any error takes two slots: a status byte that says what went wrong, followed by the character itself. The controller raises one of two service requests, one for clean data and one for an exception. It keeps these in order, so the CPU always drains clean bytes that sit ahead of an error before it sees that error. After that it presents exactly one error per service.

A service runs as follows. The CPU acknowledges the request that is raised, reads bytes with a read strobe and closes the service with an end strobe. During an exception service the first read returns the status and the second returns the data. The CPU may skip either read. Whatever it leaves unread of the pair is dropped when the service closes. A line break of any length becomes a single null character tagged with break status. Overruns of the queue are remembered and reported in the status of the next character that is stored.

Top module: `rxq_exc_ctrl`

## Requirements
- R1: After reset the queue is empty (`fill_level` = 0), `rd_is_status` is 0 and neither request is raised.
- R2: A character with no error flag occupies one slot. Clean bytes are read back in arrival order, and each accepted read lowers `fill_level` by one.
- R3: While no error pair is queued, `req_good` is raised once `fill_level` is at least `thresh` (a threshold of 0 acts as 1), and it is not raised below that level.
- R4: A character with any error occupies two slots. The first slot is a status byte, flagged by `rd_is_status` = 1, with bit 0 = parity error, bit 1 = framing error, bit 2 = overrun, bit 3 = break and the other bits 0. The second slot holds the character byte.
- R5: When an error pair is queued behind clean bytes, `req_good` is raised whatever the fill level and the threshold.
- R6: During a clean-data service a read is ignored while the head slot is a status byte, so the read never reaches into an error pair.
- R7: When a service closes and the head slot is a status byte, `req_exc` is raised. Each error pair needs its own acknowledged exception service.
- R8: During an exception service the first read returns the status byte and the second returns the data byte. Any further read in that service is ignored.
- R9: Closing an exception service drops every unread slot of its pair: both slots after no read, the data slot after one read.
- R10: A break stores one null data byte with break status. Further break-flagged writes are ignored until a write without the break flag arrives, which is stored normally.
- R11: A write is dropped if the queue has too few free slots, judged on the occupancy at the start of that cycle (one slot for a clean character, two for an error character). A dropped write sets a sticky overrun that is added to the status of the next stored character, which makes that character an error pair. `fill_level` never exceeds the depth.
- R12: At most one request is raised at a time. A raised request stays up until `svc_ack`, and no request is raised from acknowledge through to `svc_end`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | A received character is present this cycle |
| wr_char | input | 8 | Received character |
| wr_parity_err | input | 1 | Parity error on this character |
| wr_frame_err | input | 1 | Framing error on this character |
| wr_overrun | input | 1 | Overrun reported by the deserializer |
| wr_break | input | 1 | Line break condition |
| thresh | input | 5 | Fill level that triggers a clean-data request |
| svc_ack | input | 1 | CPU acknowledges the raised request |
| rd_pop | input | 1 | CPU reads the head slot |
| svc_end | input | 1 | CPU closes the current service |
| req_good | output | 1 | Clean-data service request |
| req_exc | output | 1 | Exception service request |
| rd_byte | output | 8 | Head slot byte (0 when empty) |
| rd_is_status | output | 1 | Head slot is a status byte |
| fill_level | output | 5 | Number of occupied slots |

## Verification
The checker assumes a well-behaved CPU. It acknowledges only while a request is raised, pulses `rd_pop` and `svc_end` only inside a service and closes each service with a one-cycle `svc_end`. It also assumes `thresh` is held steady while a request could be forming. The directed tasks drive every strobe for exactly one cycle, only after the matching request has been seen, and change the threshold only while no service is open. Under those conditions the checker's own tracking of open services matches the controller's.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

    // Status byte bit positions (software decodes these)
    localparam int ST_PAR = 0;
    localparam int ST_FRM = 1;
    localparam int ST_OVR = 2;
    localparam int ST_BRK = 3;

    typedef enum logic [2:0] {
        SV_IDLE,
        SV_REQ_GOOD,
        SV_REQ_EXC,
        SV_GOOD,
        SV_EXC
    } svc_state_e;

    // One queue slot: tag marks a status byte
    typedef struct packed {
        logic       tag;
        logic [7:0] val;
    } q_slot_t;

endpackage

// File: rtl/rxq_brk_gate.sv
// Turns an incoming character and its flags into a store request,
// collapsing a break of any length into a single null character.
module rxq_brk_gate
    import rxq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_valid,
    input  logic [7:0] wr_char,
    input  logic       wr_parity_err,
    input  logic       wr_frame_err,
    input  logic       wr_overrun,
    input  logic       wr_break,
    input  logic       sticky_ovr,
    output logic       st_req,
    output logic       st_err,
    output logic [7:0] st_status,
    output logic [7:0] st_data
);

    typedef struct packed {
        logic in_break;
    } gate_st_t;

    gate_st_t q, d;

    always_comb begin
        d         = q;
        st_req    = 1'b0;
        st_status = 8'h00;
        st_data   = wr_char;
        if (wr_valid) begin
            if (wr_break) begin
                if (!q.in_break) begin
                    st_req            = 1'b1;
                    st_data           = 8'h00;
                    st_status[ST_BRK] = 1'b1;
                    st_status[ST_OVR] = sticky_ovr;
                    d.in_break        = 1'b1;
                end
            end else begin
                st_req            = 1'b1;
                st_status[ST_PAR] = wr_parity_err;
                st_status[ST_FRM] = wr_frame_err;
                st_status[ST_OVR] = wr_overrun | sticky_ovr;
                d.in_break        = 1'b0;
            end
        end
        st_err = |st_status;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

endmodule

// File: rtl/rxq_store.sv
// Circular slot store taking up to two pushes and two pops per cycle.
// DEPTH must be a power of two.
module rxq_store
    import rxq_pkg::*;
#(
    parameter  int DEPTH = 16,
    localparam int AW    = $clog2(DEPTH),
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    push_n,
    input  q_slot_t       push_a,
    input  q_slot_t       push_b,
    input  logic [1:0]    pop_n,
    output q_slot_t       head,
    output logic [CW-1:0] fill
);

    typedef struct packed {
        logic [AW-1:0] wptr;
        logic [AW-1:0] rptr;
        logic [CW-1:0] fill;
    } store_st_t;

    store_st_t q, d;
    q_slot_t   mem [DEPTH];

    always_comb begin
        d      = q;
        d.wptr = q.wptr + AW'(push_n);
        d.rptr = q.rptr + AW'(pop_n);
        d.fill = q.fill + CW'(push_n) - CW'(pop_n);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_ff @(posedge clk) begin
        if (push_n != 2'd0) mem[q.wptr] <= push_a;
        if (push_n == 2'd2) mem[q.wptr + AW'(1)] <= push_b;
    end

    assign head = (q.fill != '0) ? mem[q.rptr] : '0;
    assign fill = q.fill;

endmodule

// File: rtl/rxq_sched.sv
// Service sequencer: chooses which request to raise and how many
// slots each CPU action removes.
module rxq_sched
    import rxq_pkg::*;
#(
    parameter int CW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          head_tag,
    input  logic [CW-1:0] fill,
    input  logic          exc_pend,
    input  logic [CW-1:0] thresh,
    input  logic          svc_ack,
    input  logic          rd_pop,
    input  logic          svc_end,
    output logic          req_good,
    output logic          req_exc,
    output logic [1:0]    pop_n,
    output logic          pop_status
);

    typedef struct packed {
        svc_state_e st;
        logic [1:0] exc_rd;
    } sched_st_t;

    sched_st_t q, d;

    always_comb begin
        d          = q;
        pop_n      = 2'd0;
        pop_status = 1'b0;
        unique case (q.st)
            SV_IDLE: begin
                if (fill != '0) begin
                    if (head_tag)
                        d.st = SV_REQ_EXC;
                    else if (exc_pend || (fill >= thresh))
                        d.st = SV_REQ_GOOD;
                end
            end
            SV_REQ_GOOD: if (svc_ack) d.st = SV_GOOD;
            SV_REQ_EXC: begin
                if (svc_ack) begin
                    d.st     = SV_EXC;
                    d.exc_rd = 2'd0;
                end
            end
            SV_GOOD: begin
                if (rd_pop && (fill != '0) && !head_tag) pop_n = 2'd1;
                if (svc_end) d.st = SV_IDLE;
            end
            SV_EXC: begin
                if (svc_end) begin
                    pop_n      = 2'd2 - q.exc_rd;
                    pop_status = (q.exc_rd == 2'd0);
                    d.st       = SV_IDLE;
                end else if (rd_pop && (q.exc_rd != 2'd2)) begin
                    pop_n      = 2'd1;
                    pop_status = (q.exc_rd == 2'd0);
                    d.exc_rd   = q.exc_rd + 2'd1;
                end
            end
            default: d.st = SV_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '{st: SV_IDLE, exc_rd: 2'd0};
        else        q <= d;
    end

    assign req_good = (q.st == SV_REQ_GOOD);
    assign req_exc  = (q.st == SV_REQ_EXC);

endmodule

// File: rtl/rxq_exc_ctrl.sv
module rxq_exc_ctrl
    import rxq_pkg::*;
#(
    parameter  int DEPTH = 16,
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_valid,
    input  logic [7:0]    wr_char,
    input  logic          wr_parity_err,
    input  logic          wr_frame_err,
    input  logic          wr_overrun,
    input  logic          wr_break,
    input  logic [CW-1:0] thresh,
    input  logic          svc_ack,
    input  logic          rd_pop,
    input  logic          svc_end,
    output logic          req_good,
    output logic          req_exc,
    output logic [7:0]    rd_byte,
    output logic          rd_is_status,
    output logic [CW-1:0] fill_level
);

    typedef struct packed {
        logic [CW-1:0] exc_cnt;
        logic          sticky;
    } top_st_t;

    top_st_t       q, d;
    logic          st_req, st_err;
    logic [7:0]    st_status, st_data;
    logic [1:0]    push_n, pop_n;
    logic          pop_status, drop;
    q_slot_t       push_a, push_b, head;
    logic [CW-1:0] fill, free;

    rxq_brk_gate u_gate (
        .clk           (clk),
        .rst_n         (rst_n),
        .wr_valid      (wr_valid),
        .wr_char       (wr_char),
        .wr_parity_err (wr_parity_err),
        .wr_frame_err  (wr_frame_err),
        .wr_overrun    (wr_overrun),
        .wr_break      (wr_break),
        .sticky_ovr    (q.sticky),
        .st_req        (st_req),
        .st_err        (st_err),
        .st_status     (st_status),
        .st_data       (st_data)
    );

    always_comb begin
        d      = q;
        free   = CW'(DEPTH) - fill;
        drop   = st_req && (free < (st_err ? CW'(2) : CW'(1)));
        push_n = 2'd0;
        push_a = '{tag: 1'b0, val: st_data};
        push_b = '{tag: 1'b0, val: st_data};
        if (st_req && !drop) begin
            if (st_err) begin
                push_n = 2'd2;
                push_a = '{tag: 1'b1, val: st_status};
            end else begin
                push_n = 2'd1;
            end
        end
        if (drop)                d.sticky = 1'b1;
        else if (push_n != 2'd0) d.sticky = 1'b0;
        d.exc_cnt = q.exc_cnt + CW'(push_n == 2'd2) - CW'(pop_status);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    rxq_store #(.DEPTH(DEPTH)) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .push_n (push_n),
        .push_a (push_a),
        .push_b (push_b),
        .pop_n  (pop_n),
        .head   (head),
        .fill   (fill)
    );

    rxq_sched #(.CW(CW)) u_sched (
        .clk        (clk),
        .rst_n      (rst_n),
        .head_tag   (head.tag),
        .fill       (fill),
        .exc_pend   (q.exc_cnt != '0),
        .thresh     (thresh),
        .svc_ack    (svc_ack),
        .rd_pop     (rd_pop),
        .svc_end    (svc_end),
        .req_good   (req_good),
        .req_exc    (req_exc),
        .pop_n      (pop_n),
        .pop_status (pop_status)
    );

    assign rd_byte      = head.val;
    assign rd_is_status = head.tag;
    assign fill_level   = fill;

endmodule

// File: rtl/rxq_exc_ctrl_chk.sv
module rxq_exc_ctrl_chk #(
    parameter  int DEPTH = 16,
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          svc_ack,
    input logic          rd_pop,
    input logic          svc_end,
    input logic          req_good,
    input logic          req_exc,
    input logic          rd_is_status,
    input logic [CW-1:0] fill_level
);

    logic in_svc_q, exc_svc_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_svc_q  <= 1'b0;
            exc_svc_q <= 1'b0;
        end else if ((req_good || req_exc) && svc_ack) begin
            in_svc_q  <= 1'b1;
            exc_svc_q <= req_exc;
        end else if (svc_end) begin
            in_svc_q  <= 1'b0;
        end
    end

    // R12
    p_one_req_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_good && req_exc));
    // R12
    p_good_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (req_good && !svc_ack) |=> req_good);
    // R12
    p_exc_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (req_exc && !svc_ack) |=> req_exc);
    // R12
    p_quiet_svc_r12: assert property (@(posedge clk) disable iff (!rst_n)
        in_svc_q |-> !(req_good || req_exc));
    // R7
    p_exc_head_r7: assert property (@(posedge clk) disable iff (!rst_n)
        req_exc |-> rd_is_status);
    // R11
    p_no_overflow_r11: assert property (@(posedge clk) disable iff (!rst_n)
        fill_level <= CW'(DEPTH));
    // R4
    p_fill_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        {1'b0, fill_level} <= {1'b0, $past(fill_level)} + (CW+1)'(2));
    // R6
    p_good_stop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_svc_q && !exc_svc_q && rd_pop && rd_is_status && !svc_end)
        |=> fill_level >= $past(fill_level));

endmodule

bind rxq_exc_ctrl rxq_exc_ctrl_chk #(.DEPTH(DEPTH)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .svc_ack      (svc_ack),
    .rd_pop       (rd_pop),
    .svc_end      (svc_end),
    .req_good     (req_good),
    .req_exc      (req_exc),
    .rd_is_status (rd_is_status),
    .fill_level   (fill_level)
);

// File: tb/rxq_exc_ctrl_tb.sv
`timescale 1ns/1ps
module rxq_exc_ctrl_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_valid = 1'b0;
    logic [7:0] wr_char = 8'h00;
    logic       wr_parity_err = 1'b0, wr_frame_err = 1'b0;
    logic       wr_overrun = 1'b0, wr_break = 1'b0;
    logic [4:0] thresh = 5'd4;
    logic       svc_ack = 1'b0, rd_pop = 1'b0, svc_end = 1'b0;
    logic       req_good, req_exc, rd_is_status;
    logic [7:0] rd_byte;
    logic [4:0] fill_level;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;

    always #5 clk = ~clk;

    rxq_exc_ctrl u_dut (
        .clk (clk), .rst_n (rst_n),
        .wr_valid (wr_valid), .wr_char (wr_char),
        .wr_parity_err (wr_parity_err), .wr_frame_err (wr_frame_err),
        .wr_overrun (wr_overrun), .wr_break (wr_break),
        .thresh (thresh), .svc_ack (svc_ack), .rd_pop (rd_pop),
        .svc_end (svc_end), .req_good (req_good), .req_exc (req_exc),
        .rd_byte (rd_byte), .rd_is_status (rd_is_status),
        .fill_level (fill_level)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic put(input logic [7:0] c, input logic p, input logic f,
                       input logic o, input logic b);
        @(negedge clk);
        wr_valid = 1'b1; wr_char = c;
        wr_parity_err = p; wr_frame_err = f; wr_overrun = o; wr_break = b;
        @(negedge clk);
        wr_valid = 1'b0; wr_parity_err = 1'b0; wr_frame_err = 1'b0;
        wr_overrun = 1'b0; wr_break = 1'b0;
    endtask

    task automatic wait_req(input bit exc, input string req);
        for (int i = 0; i < 10; i++) begin
            if (exc ? req_exc : req_good) break;
            @(negedge clk);
        end
        check(exc ? (req_exc && !req_good) : (req_good && !req_exc), req,
              {req_exc, req_good}, exc ? 2 : 1);
    endtask

    task automatic ack();
        @(negedge clk); svc_ack = 1'b1;
        @(negedge clk); svc_ack = 1'b0;
        check(!req_good && !req_exc, "R12", {req_exc, req_good}, 0);
    endtask

    task automatic rd(output logic [7:0] v, output logic s);
        @(negedge clk);
        v = rd_byte; s = rd_is_status; rd_pop = 1'b1;
        @(negedge clk); rd_pop = 1'b0;
    endtask

    task automatic fin();
        @(negedge clk); svc_end = 1'b1;
        @(negedge clk); svc_end = 1'b0;
    endtask

    task automatic rd_expect(input logic [7:0] ev, input logic es, input string req);
        logic [7:0] v; logic s;
        rd(v, s);
        check(v == ev && s == es, req, {s, v}, {es, ev});
    endtask

    task automatic t_reset();
        check(fill_level == 0, "R1", fill_level, 0);
        check(!req_good && !req_exc && !rd_is_status, "R1",
              {rd_is_status, req_exc, req_good}, 0);
    endtask

    task automatic t_threshold();
        thresh = 5'd4;
        put(8'h11, 0, 0, 0, 0); put(8'h22, 0, 0, 0, 0); put(8'h33, 0, 0, 0, 0);
        check(fill_level == 3, "R2", fill_level, 3);
        repeat (4) @(negedge clk);
        check(!req_good, "R3", req_good, 0);
        put(8'h44, 0, 0, 0, 0);
        wait_req(0, "R3");
        repeat (3) @(negedge clk);
        check(req_good, "R12", req_good, 1);
        ack();
        rd_expect(8'h11, 0, "R2"); rd_expect(8'h22, 0, "R2");
        rd_expect(8'h33, 0, "R2"); rd_expect(8'h44, 0, "R2");
        check(fill_level == 0, "R2", fill_level, 0);
        fin();
        repeat (3) @(negedge clk);
        check(!req_good && !req_exc, "R3", {req_exc, req_good}, 0);
    endtask

    task automatic t_order();
        logic [7:0] v; logic s;
        thresh = 5'd8;
        put(8'h41, 0, 0, 0, 0);
        repeat (3) @(negedge clk);
        check(!req_good, "R3", req_good, 0);
        put(8'h5A, 1, 0, 0, 0);
        put(8'h66, 0, 0, 0, 0);
        check(fill_level == 4, "R4", fill_level, 4);
        wait_req(0, "R5");
        ack();
        rd_expect(8'h41, 0, "R2");
        rd(v, s);
        check(s == 1'b1 && fill_level == 3, "R6", {s, fill_level}, {1'b1, 5'd3});
        fin();
        wait_req(1, "R7");
        ack();
        rd_expect(8'h01, 1, "R8");
        rd_expect(8'h5A, 0, "R8");
        rd(v, s);
        check(fill_level == 1 && rd_byte == 8'h66, "R8",
              {fill_level, rd_byte}, {5'd1, 8'h66});
        fin();
        repeat (4) @(negedge clk);
        check(!req_good && !req_exc, "R3", {req_exc, req_good}, 0);
        thresh = 5'd1;
        wait_req(0, "R3");
        ack(); rd_expect(8'h66, 0, "R2"); fin();
        thresh = 5'd8;
    endtask

    task automatic t_discard();
        put(8'h12, 0, 1, 0, 0);
        put(8'h34, 0, 0, 1, 0);
        check(fill_level == 4, "R4", fill_level, 4);
        wait_req(1, "R7");
        ack(); fin();
        check(fill_level == 2, "R9", fill_level, 2);
        wait_req(1, "R7");
        ack();
        rd_expect(8'h04, 1, "R4");
        fin();
        check(fill_level == 0, "R9", fill_level, 0);
    endtask

    task automatic t_break();
        for (int i = 0; i < 5; i++) put(8'hFF, 0, 0, 0, 1);
        check(fill_level == 2, "R10", fill_level, 2);
        put(8'h77, 0, 0, 0, 0);
        check(fill_level == 3, "R10", fill_level, 3);
        put(8'hFF, 0, 0, 0, 1);
        check(fill_level == 5, "R10", fill_level, 5);
        wait_req(1, "R7");
        ack();
        rd_expect(8'h08, 1, "R10"); rd_expect(8'h00, 0, "R10");
        fin();
        wait_req(0, "R5");
        ack(); rd_expect(8'h77, 0, "R10"); fin();
        wait_req(1, "R7");
        ack();
        rd_expect(8'h08, 1, "R10"); rd_expect(8'h00, 0, "R10");
        fin();
        check(fill_level == 0, "R9", fill_level, 0);
    endtask

    task automatic t_overflow();
        thresh = 5'd16;
        for (int i = 0; i < 16; i++) put(8'(i), 0, 0, 0, 0);
        check(fill_level == 16, "R11", fill_level, 16);
        put(8'hAA, 0, 0, 0, 0);
        check(fill_level == 16, "R11", fill_level, 16);
        wait_req(0, "R3");
        ack();
        for (int i = 0; i < 16; i++) rd_expect(8'(i), 0, "R11");
        fin();
        put(8'hBB, 0, 0, 0, 0);
        check(fill_level == 2, "R11", fill_level, 2);
        wait_req(1, "R7");
        ack();
        rd_expect(8'h04, 1, "R11"); rd_expect(8'hBB, 0, "R11");
        fin();
        check(fill_level == 0, "R11", fill_level, 0);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_threshold();
        t_order();
        t_discard();
        t_break();
        t_overflow();
        repeat (3) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule